// File: doc/BRIEF.md
# Tagged Micro-Word Packet Reassembler

This block rebuilds fixed-length 188-byte transport packets from a stream of 32-bit micro-words. Each micro-word names one of several logical streams, carries a rolling 3-bit sequence number, a packet-start flag, an upstream-overflow flag and three payload bytes. A full packet is spread across 63 micro-words of the same stream. Words from different streams may be freely interleaved. The block keeps a separate word position and sequence state for every stream, so each stream is reassembled on its own.

Reassembled bytes leave one per cycle on a valid/ready byte port tagged with the stream index and with start-of-packet and end-of-packet markers. Input words arrive on a valid/ready port. The block accepts a new word only when its holding register has drained, or is draining its last byte in this same cycle. When the downstream consumer holds `out_ready` low, the holding register stalls and `in_ready` drops. Nothing is lost. Upstream overflow and sequence gaps are reported as one-cycle status pulses. A one-cycle done pulse marks every completed packet.

Word layout: bits 31:29 hold the stream number plus one. Bits 28:26 hold the sequence number. Bit 25 is the start flag, bit 24 is the overflow flag, and bits 23:0 carry the payload.

Top module: `mpr_reasm`

## Requirements
- R1: A word whose tag field (bits 31:29) is 0 or greater than the stream count (4) is discarded: it produces no output byte and changes no stream state. Tag values 1..4 select streams 0..3.
- R2: A word with bit 25 set restarts its stream at word position 0. A word with bit 25 clear is discarded while its stream sits at position 0. This covers the time after reset and the time after a completed packet.
- R3: An accepted word emits its payload bytes in the order bits 23:16, then 15:8, then 7:0, on `out_byte`.
- R4: Word positions 0..61 emit three bytes and position 62 emits only its first two bytes, so a packet is exactly 188 bytes. `out_sop` marks the first byte of position 0 and `out_eop` marks the last byte of position 62. After position 62 the stream returns to position 0.
- R5: `out_stream` carries the stream index of every byte. Interleaved streams keep independent positions and sequence state.
- R6: For a kept word, if its stream has seen an earlier kept word since reset and bits 28:26 differ from that word's sequence number plus one (mod 8), then `err_loss` pulses in the next cycle with `err_stream` set to the stream. The first kept word of a stream after reset is never flagged.
- R7: A kept word with bit 24 set pulses `err_ovf` in the next cycle with `err_stream` set. Its bytes are still emitted normally. Discarded words raise no flag.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_stream`, `out_sop` and `out_eop` hold steady. `in_ready` is high exactly when no byte is held, or when one byte is held and `out_ready` is high.
- R9: `pkt_done` pulses for one cycle in the cycle after a byte marked `out_eop` is accepted, with `pkt_stream` set to that byte's stream.
- R10: While reset is low, `out_valid`, `pkt_done`, `err_ovf` and `err_loss` are low, `in_ready` is high, and every stream returns to position 0 with no sequence history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_word | input | 32 | Tagged micro-word |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_byte | output | 8 | Reassembled payload byte |
| out_stream | output | 2 | Stream index of the output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| pkt_done | output | 1 | One-cycle pulse after a packet's last byte is taken |
| pkt_stream | output | 2 | Stream of the finished packet |
| err_ovf | output | 1 | Upstream overflow seen on a kept word |
| err_loss | output | 1 | Sequence gap seen on a kept word |
| err_stream | output | 2 | Stream that the error pulses refer to |

## Verification
The assertions check the cycle-local rules on every clock. These are: byte stability under stall, `in_ready` whenever nothing is held, silence after a word with a bad tag, a start-of-packet byte after every started word, the done pulse following each accepted end byte, and the error pulses arising only from accepted words. Only the bench's scenarios can show the properties that need per-stream history. These are the 188-byte packet length, the discarding of unsynchronised words, byte order across interleaved streams, the sequence check skipping a stream's first word, and the exact cycles of loss and overflow pulses. The bench checks them against its own model of every stream.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int MPR_NSTR_DEF = 4;
  localparam int MPR_WPP_DEF  = 63;
  localparam int MPR_SEQW     = 3;

  typedef struct packed {
    logic [2:0]          tag;
    logic [MPR_SEQW-1:0] seq;
    logic                start;
    logic                ovf;
    logic [23:0]         pay;
  } mpr_word_t;
endpackage

// File: rtl/mpr_lane.sv
module mpr_lane #(
  parameter int WPP  = 63,
  parameter int PW   = 6,
  parameter int SEQW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            start,
  input  logic [SEQW-1:0] seq_in,
  output logic [PW-1:0]   pos,
  output logic [SEQW-1:0] seq_last,
  output logic            seq_vld
);
  logic [PW-1:0] eff;
  assign eff = start ? '0 : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      seq_last <= '0;
      seq_vld  <= 1'b0;
    end else if (upd) begin
      pos      <= (eff == PW'(WPP - 1)) ? '0 : eff + 1'b1;
      seq_last <= seq_in;
      seq_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/mpr_drain.sv
module mpr_drain #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [23:0]   ld_bytes,
  input  logic [1:0]    ld_cnt,
  input  logic          ld_sop,
  input  logic          ld_eop,
  input  logic [SW-1:0] ld_stream,
  output logic          can_load,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic [SW-1:0] out_stream,
  output logic          out_sop,
  output logic          out_eop
);
  logic [23:0]   shreg;
  logic [1:0]    cnt;
  logic          sop_q, eop_q;
  logic [SW-1:0] strm_q;
  logic          pop;

  assign out_valid  = (cnt != 2'd0);
  assign pop        = out_valid && out_ready;
  assign can_load   = (cnt == 2'd0) || ((cnt == 2'd1) && out_ready);
  assign out_byte   = shreg[23:16];
  assign out_stream = strm_q;
  assign out_sop    = sop_q;
  assign out_eop    = eop_q && (cnt == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      strm_q <= '0;
    end else if (load) begin
      shreg  <= ld_bytes;
      cnt    <= ld_cnt;
      sop_q  <= ld_sop;
      eop_q  <= ld_eop;
      strm_q <= ld_stream;
    end else if (pop) begin
      shreg  <= {shreg[15:0], 8'h00};
      cnt    <= cnt - 2'd1;
      sop_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/mpr_reasm.sv
module mpr_reasm #(
  parameter int NSTR = mpr_pkg::MPR_NSTR_DEF,
  parameter int WPP  = mpr_pkg::MPR_WPP_DEF,
  localparam int SW  = (NSTR > 1) ? $clog2(NSTR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_byte,
  output logic [SW-1:0] out_stream,
  output logic          out_sop,
  output logic          out_eop,
  output logic          pkt_done,
  output logic [SW-1:0] pkt_stream,
  output logic          err_ovf,
  output logic          err_loss,
  output logic [SW-1:0] err_stream
);
  import mpr_pkg::*;
  localparam int PW   = $clog2(WPP);
  localparam int SEQW = MPR_SEQW;

  mpr_word_t w;
  assign w = mpr_word_t'(in_word);

  logic          tag_ok, acc, keep;
  logic [SW-1:0] sid;
  assign tag_ok = (w.tag != 3'd0) && (int'(w.tag) <= NSTR);
  assign sid    = SW'(w.tag - 3'd1);
  assign acc    = in_valid && in_ready;

  logic [PW-1:0]   pos_v   [NSTR];
  logic [SEQW-1:0] seq_v   [NSTR];
  logic [NSTR-1:0] seqok_v;
  logic [NSTR-1:0] upd_v;

  logic [PW-1:0]   cur_pos;
  logic [SEQW-1:0] cur_seq;
  logic            cur_seqok;

  always_comb begin
    cur_pos   = '0;
    cur_seq   = '0;
    cur_seqok = 1'b0;
    for (int i = 0; i < NSTR; i++) begin
      if (tag_ok && sid == SW'(i)) begin
        cur_pos   = pos_v[i];
        cur_seq   = seq_v[i];
        cur_seqok = seqok_v[i];
      end
    end
  end

  assign keep = acc && tag_ok && (w.start || cur_pos != '0);

  genvar g;
  generate
    for (g = 0; g < NSTR; g++) begin : g_lane
      assign upd_v[g] = keep && (sid == SW'(g));
      mpr_lane #(.WPP(WPP), .PW(PW), .SEQW(SEQW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd_v[g]),
        .start    (w.start),
        .seq_in   (w.seq),
        .pos      (pos_v[g]),
        .seq_last (seq_v[g]),
        .seq_vld  (seqok_v[g])
      );
    end
  endgenerate

  logic [PW-1:0] eff_pos;
  logic          last_word, loss_now;
  assign eff_pos   = w.start ? '0 : cur_pos;
  assign last_word = (eff_pos == PW'(WPP - 1));
  assign loss_now  = keep && cur_seqok && (w.seq != cur_seq + 1'b1);

  mpr_drain #(.SW(SW)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (keep),
    .ld_bytes   (w.pay),
    .ld_cnt     (last_word ? 2'd2 : 2'd3),
    .ld_sop     (eff_pos == '0),
    .ld_eop     (last_word),
    .ld_stream  (sid),
    .can_load   (in_ready),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_stream (out_stream),
    .out_sop    (out_sop),
    .out_eop    (out_eop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_done   <= 1'b0;
      pkt_stream <= '0;
      err_ovf    <= 1'b0;
      err_loss   <= 1'b0;
      err_stream <= '0;
    end else begin
      pkt_done <= out_valid && out_ready && out_eop;
      if (out_valid && out_ready && out_eop) pkt_stream <= out_stream;
      err_ovf  <= keep && w.ovf;
      err_loss <= loss_now;
      if (keep) err_stream <= sid;
    end
  end
endmodule

// File: rtl/mpr_reasm_checks.sv
module mpr_reasm_checks #(
  parameter int NSTR = 4,
  parameter int SW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [31:0]   in_word,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_byte,
  input logic [SW-1:0] out_stream,
  input logic          out_sop,
  input logic          out_eop,
  input logic          pkt_done,
  input logic [SW-1:0] pkt_stream,
  input logic          err_ovf,
  input logic          err_loss
);
  logic acc, good_tag;
  assign acc      = in_valid && in_ready;
  assign good_tag = (in_word[31:29] != 3'd0) && (int'(in_word[31:29]) <= NSTR);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_stream)
                                && $stable(out_sop) && $stable(out_eop));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_bad_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !good_tag |=> !out_valid);

  p_start_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && good_tag && in_word[25] |=> out_valid && out_sop);

  p_markers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sop && out_eop));

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> pkt_done && pkt_stream == $past(out_stream));

  p_loss_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_loss |-> $past(acc));

  p_ovf_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> $past(acc));

  p_ovf_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && good_tag && in_word[25] && in_word[24] |=> err_ovf);
endmodule

bind mpr_reasm mpr_reasm_checks #(.NSTR(NSTR), .SW(SW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_byte   (out_byte),
  .out_stream (out_stream),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .pkt_done   (pkt_done),
  .pkt_stream (pkt_stream),
  .err_ovf    (err_ovf),
  .err_loss   (err_loss)
);

// File: tb/mpr_reasm_bench.sv
module mpr_reasm_bench;
  localparam int NSTR = 4;
  localparam int WPP  = 63;
  localparam int PKT  = 3 * WPP - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic [1:0]  out_stream;
  logic        out_sop, out_eop;
  logic        pkt_done;
  logic [1:0]  pkt_stream;
  logic        err_ovf, err_loss;
  logic [1:0]  err_stream;

  always #4 clk = ~clk;

  mpr_reasm u_mpr_reasm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_stream(out_stream),
    .out_sop(out_sop), .out_eop(out_eop), .pkt_done(pkt_done), .pkt_stream(pkt_stream),
    .err_ovf(err_ovf), .err_loss(err_loss), .err_stream(err_stream)
  );

  typedef struct { logic [7:0] b; int s; bit sop; bit eop; } ob_t;

  int   checks = 0, fails = 0, cycles = 0;
  bit   timed_out = 0;
  int   m_pos [NSTR];
  int   m_seq [NSTR];
  bit   m_seqv[NSTR];
  int   bcnt  [NSTR];
  int   g_pos [NSTR];
  int   g_seq [NSTR];
  ob_t  q[$];
  bit   exp_ovf, exp_loss, exp_done;
  int   exp_es, exp_ds;
  int   done_seen = 0, done_exp = 0;
  int   out_pct = 100, in_pct = 100;
  logic [31:0] pend;
  bit   have = 0;
  bit   stall_prev = 0;
  logic [7:0] stall_b;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(int tag, int sq, bit st, bit ov, logic [23:0] p);
    return {3'(tag), 3'(sq), st, ov, p};
  endfunction

  function automatic void model(logic [31:0] w);
    int tag = int'(w[31:29]);
    int s, eff, n;
    exp_ovf = 0; exp_loss = 0;
    if (tag < 1 || tag > NSTR) return;
    s = tag - 1;
    if (!w[25] && m_pos[s] == 0) return;
    eff = w[25] ? 0 : m_pos[s];
    exp_ovf  = w[24];
    exp_loss = m_seqv[s] && (int'(w[28:26]) != ((m_seq[s] + 1) % 8));
    exp_es   = s;
    m_seq[s] = int'(w[28:26]); m_seqv[s] = 1;
    n = (eff == WPP - 1) ? 2 : 3;
    for (int k = 0; k < n; k++)
      q.push_back('{w[23 - 8*k -: 8], s, (eff == 0) && (k == 0), (eff == WPP - 1) && (k == n - 1)});
    m_pos[s] = (eff == WPP - 1) ? 0 : eff + 1;
  endfunction

  task automatic cycle();
    ob_t e;
    @(negedge clk);
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1; checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    end
    if (exp_ovf || err_ovf) chk(err_ovf == exp_ovf, "R7", "err_ovf", err_ovf, exp_ovf);
    if (exp_loss || err_loss) chk(err_loss == exp_loss, "R6", "err_loss", err_loss, exp_loss);
    if (exp_ovf || exp_loss) chk(int'(err_stream) == exp_es, "R6", "err_stream", err_stream, exp_es);
    if (exp_done || pkt_done) begin
      chk(pkt_done == exp_done, "R9", "pkt_done", pkt_done, exp_done);
      if (exp_done) chk(int'(pkt_stream) == exp_ds, "R9", "pkt_stream", pkt_stream, exp_ds);
    end
    if (pkt_done) done_seen++;
    exp_ovf = 0; exp_loss = 0; exp_done = 0;
    out_ready = (($urandom % 100) < out_pct);
    in_valid  = have && (($urandom % 100) < in_pct);
    in_word   = pend;
    #1;
    chk(in_ready == (q.size() == 0 || (q.size() == 1 && out_ready)), "R8", "in_ready",
        in_ready, q.size());
    if (stall_prev) chk(out_valid && out_byte == stall_b, "R8", "stalled byte", out_byte, stall_b);
    if (out_valid) begin
      if (q.size() == 0) chk(0, "R1", "unexpected byte", out_byte, -1);
      else begin
        e = q[0];
        chk(out_byte == e.b, "R3", "byte", out_byte, e.b);
        chk(int'(out_stream) == e.s, "R5", "stream", out_stream, e.s);
        chk(out_sop == e.sop && out_eop == e.eop, "R4", "sop/eop", {out_sop, out_eop}, {e.sop, e.eop});
        if (out_ready) begin
          void'(q.pop_front());
          if (e.sop) bcnt[e.s] = 1; else bcnt[e.s]++;
          if (e.eop) begin
            chk(bcnt[e.s] == PKT, "R4", "packet length", bcnt[e.s], PKT);
            exp_done = 1; exp_ds = e.s; done_exp++;
          end
        end
      end
    end else if (q.size() != 0) chk(0, "R3", "out_valid", 0, 1);
    stall_prev = out_valid && !out_ready;
    stall_b    = out_byte;
    if (in_valid && in_ready) begin
      model(in_word);
      have = 0;
    end
  endtask

  task automatic send(logic [31:0] w);
    pend = w; have = 1;
    while (have && !timed_out) cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  function automatic logic [31:0] gen();
    int s = $urandom % NSTR;
    int r = $urandom % 100;
    bit st;
    if (r < 3) return mkw((r == 0) ? 0 : 5 + ($urandom % 3), $urandom % 8, 1, 0, 24'($urandom));
    st = (g_pos[s] == 0) ? (($urandom % 100) < 90) : (($urandom % 100) < 1);
    if (st) g_pos[s] = 0;
    g_pos[s] = (g_pos[s] + 1) % WPP;
    g_seq[s] = (g_seq[s] + ((($urandom % 100) < 3) ? 2 : 1)) % 8;
    return mkw(s + 1, g_seq[s], st, (($urandom % 100) < 3), 24'($urandom));
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NSTR; i++) begin
      m_pos[i] = 0; m_seq[i] = 0; m_seqv[i] = 0; bcnt[i] = 0; g_pos[i] = 0; g_seq[i] = 0;
    end
    exp_ovf = 0; exp_loss = 0; exp_done = 0; exp_es = 0; exp_ds = 0;
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !pkt_done && !err_ovf && !err_loss, "R10", "outputs in reset",
        {out_valid, pkt_done, err_ovf, err_loss}, 0);
    chk(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R2: no start on an unsynchronised stream; R1: bad tags
    send(mkw(1, 0, 0, 0, 24'hA1A2A3));
    send(mkw(0, 0, 1, 1, 24'hB1B2B3));
    send(mkw(5, 0, 1, 1, 24'hC1C2C3));
    send(mkw(7, 0, 1, 0, 24'hD1D2D3));
    idle(3);
    chk(!out_valid, "R1", "no output after discarded words", out_valid, 0);
    chk(!err_ovf, "R1", "no overflow from bad tag", err_ovf, 0);

    // R4/R9: one full packet on stream 1, first sequence 5 unchecked (R6)
    for (int k = 0; k < WPP; k++)
      send(mkw(2, (5 + k) % 8, k == 0, 0, {8'(k), 8'(k + 64), 8'(k + 128)}));
    idle(6);
    chk(done_seen == 1, "R9", "packets done", done_seen, 1);

    // R2: position back at zero after a packet, so a non-start word is dropped
    send(mkw(2, 4, 0, 0, 24'h111213));
    idle(3);
    chk(!out_valid, "R2", "dropped after packet end", out_valid, 0);

    // R8: stall with bytes held
    out_pct = 0;
    send(mkw(3, 2, 1, 0, 24'h313233));
    idle(4);
    chk(out_valid && out_byte == 8'h31, "R8", "held first byte", out_byte, 8'h31);
    out_pct = 100;
    // R6 gap and R7 overflow on stream 2
    send(mkw(3, 4, 0, 0, 24'h343536));
    send(mkw(3, 5, 0, 1, 24'h373839));
    // R5: interleave a restart on stream 3
    send(mkw(4, 0, 1, 0, 24'h414243));
    send(mkw(3, 6, 0, 0, 24'h3A3B3C));
    idle(6);

    // random mix
    out_pct = 70; in_pct = 80;
    for (int i = 0; i < 4000 && !timed_out; i++) send(gen());
    out_pct = 100; in_pct = 100;
    idle(20);
    chk(q.size() == 0, "R3", "bytes left", q.size(), 0);
    chk(done_seen == done_exp, "R9", "done count", done_seen, done_exp);
    chk(done_exp > 4, "R4", "packets completed in random phase", done_exp, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule